// File: doc/BRIEF.md
# Dual-Buffer Audio Fetch Address Sequencer

This block generates the memory addresses for an audio DMA channel. It keeps two register sets, A and B. Each set has a current pointer, made of a page number and an offset within that page, and an end register. The end register holds an end offset and two control bits, stop and last. The active set presents its address as a fetch request. Each acknowledged fetch moves the offset forward by one 16-byte unit. The offset wraps inside the page and never carries into the page number.

When the fetch at the end offset is acknowledged, one of two things happens. If the stop bit is clear, the block switches to the other set and pulses a buffer-switch flag, so software can refill the set that just finished. If the stop bit is set, the channel halts on the same set. A set whose last bit is 1 describes a single transfer: its next fetch goes straight to the end location.

A control register holds the channel enable bit. All registers are reached through a simple single-cycle write and combinational read port.

Top module: `pingpong_dma_addr`

## Requirements
- R1: After reset, set A is active (`active_set` = 0). `fetch_req`, `halted` and `buf_switch` are low, and every register reads zero.
- R2: The current-pointer registers are at index 0 (A) and 2 (B). The page sits in bits 28:12 and the offset in bits 11:4. A read returns those bits, with bits 31:29 and 3:0 reading zero.
- R3: The end registers are at index 1 (A) and 3 (B). The stop bit is bit 31, the last bit is bit 30 and the end offset is bits 11:4. A read returns exactly those bits, with all other bits reading zero.
- R4: While fetching, `fetch_addr` equals the active set's {page, offset, 4'b0000}. Each cycle with both `fetch_req` and `fetch_ack` high advances the offset by one. The address holds while no acknowledge arrives.
- R5: An offset of 0xFF advances to 0x00, and the page number does not change.
- R6: An acknowledged fetch at the end offset with stop = 0 switches the active set. `buf_switch` is high for one cycle, starting in the cycle after the acknowledge. The next address comes from the other set's current pointer.
- R7: An acknowledged fetch at the end offset with stop = 1 sets `halted` and drops `fetch_req`. `active_set` stays unchanged. The pointer of the finished set still advances past the end offset.
- R8: When the active set's last bit is 1, its next fetch is taken at the end offset, whatever the current offset is. That fetch is handled as an end fetch.
- R9: A write to the active set's current pointer while the channel runs sets the address of the very next fetch.
- R10: The control register is at index 4, with bit 0 as the enable. A read returns the enable in bit 0. Any write to it clears `halted`. Clearing the enable drops `fetch_req` and leaves both pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| fetch_req | output | 1 | Fetch request |
| fetch_addr | output | 29 | Byte address of the requested 16-byte unit |
| fetch_ack | input | 1 | Fetch accepted |
| active_set | output | 1 | Active register set (0 = A, 1 = B) |
| buf_switch | output | 1 | One-cycle pulse after a switch of set |
| halted | output | 1 | Channel stopped at an end location |

## Verification
Set A runs from a middle offset up to a plain end. This separates a correct switch from a missing or early switch. Set B starts just below the top of its page and ends past the wrap with stop set. This shows that the offset wraps without touching the page, and that stop halts instead of switching.

Three further cases isolate single features. A rewrite of the running pointer, a last-bit set whose current offset lies far from its end, and an enable toggle separate immediate pointer updates, the end-location jump and pointer retention. A stretch with no acknowledge confirms that the address does not move on its own.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
   typedef enum logic [2:0] {
      RI_CUR_A = 3'd0,
      RI_END_A = 3'd1,
      RI_CUR_B = 3'd2,
      RI_END_B = 3'd3,
      RI_CTRL  = 3'd4
   } reg_idx_e;

   localparam int STOP_POS = 31;
   localparam int LAST_POS = 30;
   localparam int NUM_SETS = 2;
endpackage

// File: rtl/ppdma_regset.sv
module ppdma_regset #(
   parameter int PAGE_W     = 17,
   parameter int OFS_W      = 8,
   parameter int UNIT_SHIFT = 4,
   parameter bit LAST_JUMPS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cur_we,
   input  logic              end_we,
   input  logic [PAGE_W-1:0] wr_page,
   input  logic [OFS_W-1:0]  wr_ofs,
   input  logic              wr_stop,
   input  logic              wr_last,
   input  logic              adv_i,
   output logic [PAGE_W-1:0] page_o,
   output logic [OFS_W-1:0]  fetch_ofs_o,
   output logic              at_end_o,
   output logic              stop_o,
   output logic [31:0]       cur_rd_o,
   output logic [31:0]       end_rd_o
);
   import pp_dma_pkg::*;
   localparam int PAGE_LSB = UNIT_SHIFT + OFS_W;

   logic [PAGE_W-1:0] page_q;
   logic [OFS_W-1:0]  ofs_q, end_q;
   logic              stop_q, last_q;

   generate
      if (LAST_JUMPS) begin : g_jump
         assign fetch_ofs_o = last_q ? end_q : ofs_q;
      end else begin : g_mark
         assign fetch_ofs_o = ofs_q;
      end
   endgenerate

   assign at_end_o = last_q || (ofs_q == end_q);
   assign page_o   = page_q;
   assign stop_o   = stop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         ofs_q  <= '0;
      end else if (cur_we) begin
         page_q <= wr_page;
         ofs_q  <= wr_ofs;
      end else if (adv_i) begin
         ofs_q  <= OFS_W'(fetch_ofs_o + 1'b1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         end_q  <= '0;
         stop_q <= 1'b0;
         last_q <= 1'b0;
      end else if (end_we) begin
         end_q  <= wr_ofs;
         stop_q <= wr_stop;
         last_q <= wr_last;
      end
   end

   always_comb begin
      cur_rd_o = '0;
      cur_rd_o[UNIT_SHIFT +: OFS_W] = ofs_q;
      cur_rd_o[PAGE_LSB +: PAGE_W]  = page_q;
      end_rd_o = '0;
      end_rd_o[UNIT_SHIFT +: OFS_W] = end_q;
      end_rd_o[STOP_POS] = stop_q;
      end_rd_o[LAST_POS] = last_q;
   end

   // R4: an idle cycle leaves the pointer where it was
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !cur_we) |=> ($stable(ofs_q) && $stable(page_q)));
   // R5: advancing never changes the page
   p_page_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !cur_we) |=> $stable(page_q));
endmodule

// File: rtl/ppdma_seq.sv
module ppdma_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_we,
   input  logic ctrl_en,
   input  logic fetch_ack,
   input  logic at_end,
   input  logic stop,
   output logic fetch_req,
   output logic fire_o,
   output logic active_o,
   output logic buf_switch_o,
   output logic halted_o,
   output logic enable_o
);
   logic enable_q, halted_q, active_q, switch_q;

   assign fetch_req    = enable_q && !halted_q;
   assign fire_o       = fetch_req && fetch_ack;
   assign active_o     = active_q;
   assign buf_switch_o = switch_q;
   assign halted_o     = halted_q;
   assign enable_o     = enable_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= 1'b0;
         halted_q <= 1'b0;
         active_q <= 1'b0;
         switch_q <= 1'b0;
      end else begin
         switch_q <= 1'b0;
         if (fire_o && at_end) begin
            if (stop) begin
               halted_q <= 1'b1;
            end else begin
               active_q <= ~active_q;
               switch_q <= 1'b1;
            end
         end
         if (ctrl_we) begin
            enable_q <= ctrl_en;
            halted_q <= 1'b0;
         end
      end
   end

   // R6: every change of set is flagged
   p_switch_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active_q) |-> switch_q);
   // R7: halting keeps the set
   p_halt_keeps_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted_q) |-> $stable(active_q));
   // R10: no request without enable
   p_req_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> enable_q);
endmodule

// File: rtl/pingpong_dma_addr.sv
module pingpong_dma_addr #(
   parameter int PAGE_W     = 17,
   parameter int OFS_W      = 8,
   parameter int UNIT_SHIFT = 4,
   parameter bit LAST_JUMPS = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                reg_we,
   input  logic [2:0]                          reg_addr,
   input  logic [31:0]                         reg_wdata,
   output logic [31:0]                         reg_rdata,
   output logic                                fetch_req,
   output logic [PAGE_W+OFS_W+UNIT_SHIFT-1:0]  fetch_addr,
   input  logic                                fetch_ack,
   output logic                                active_set,
   output logic                                buf_switch,
   output logic                                halted
);
   import pp_dma_pkg::*;
   localparam int PAGE_LSB = UNIT_SHIFT + OFS_W;
   localparam int ADDR_W   = PAGE_LSB + PAGE_W;

   if (ADDR_W > LAST_POS) begin : g_bad_width
      $error("pointer fields overlap the control bits");
   end
   if (OFS_W < 1 || PAGE_W < 1) begin : g_bad_field
      $error("page and offset need at least one bit");
   end

   logic [PAGE_W-1:0] page_w    [NUM_SETS];
   logic [OFS_W-1:0]  ofs_w     [NUM_SETS];
   logic              at_end_w  [NUM_SETS];
   logic              stop_w    [NUM_SETS];
   logic [31:0]       cur_rd_w  [NUM_SETS];
   logic [31:0]       end_rd_w  [NUM_SETS];
   logic              fire, enable, unused_wdata;

   assign unused_wdata = ^reg_wdata;

   for (genvar i = 0; i < NUM_SETS; i++) begin : g_set
      ppdma_regset #(
         .PAGE_W(PAGE_W), .OFS_W(OFS_W),
         .UNIT_SHIFT(UNIT_SHIFT), .LAST_JUMPS(LAST_JUMPS)
      ) set_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .cur_we     (reg_we && reg_addr == 3'(2*i)),
         .end_we     (reg_we && reg_addr == 3'(2*i+1)),
         .wr_page    (reg_wdata[PAGE_LSB +: PAGE_W]),
         .wr_ofs     (reg_wdata[UNIT_SHIFT +: OFS_W]),
         .wr_stop    (reg_wdata[STOP_POS]),
         .wr_last    (reg_wdata[LAST_POS]),
         .adv_i      (fire && (active_set == 1'(i))),
         .page_o     (page_w[i]),
         .fetch_ofs_o(ofs_w[i]),
         .at_end_o   (at_end_w[i]),
         .stop_o     (stop_w[i]),
         .cur_rd_o   (cur_rd_w[i]),
         .end_rd_o   (end_rd_w[i])
      );
   end

   ppdma_seq seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl_we     (reg_we && reg_addr == RI_CTRL),
      .ctrl_en     (reg_wdata[0]),
      .fetch_ack   (fetch_ack),
      .at_end      (at_end_w[active_set]),
      .stop        (stop_w[active_set]),
      .fetch_req   (fetch_req),
      .fire_o      (fire),
      .active_o    (active_set),
      .buf_switch_o(buf_switch),
      .halted_o    (halted),
      .enable_o    (enable)
   );

   assign fetch_addr = {page_w[active_set], ofs_w[active_set], {UNIT_SHIFT{1'b0}}};

   always_comb begin
      case (reg_addr)
         RI_CUR_A: reg_rdata = cur_rd_w[0];
         RI_END_A: reg_rdata = end_rd_w[0];
         RI_CUR_B: reg_rdata = cur_rd_w[1];
         RI_END_B: reg_rdata = end_rd_w[1];
         RI_CTRL:  reg_rdata = {31'd0, enable};
         default:  reg_rdata = '0;
      endcase
   end

   // R7: a halted channel requests nothing
   p_halt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !fetch_req);
   // R6: the switch flag lasts one cycle unless a second end fetch follows
   p_switch_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_switch && !fire) |=> !buf_switch);
endmodule

// File: tb/pingpong_dma_addr_tb_top.sv
`timescale 1ns/1ps
module pingpong_dma_addr_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        fetch_req, fetch_ack = 1'b0;
   logic [28:0] fetch_addr;
   logic        active_set, buf_switch, halted;

   int n_chk = 0, n_fail = 0;
   logic [28:0] exp_q [$];
   string       tag_q [$];

   always #2 clk = ~clk;

   pingpong_dma_addr dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_req(fetch_req),
      .fetch_addr(fetch_addr), .fetch_ack(fetch_ack), .active_set(active_set),
      .buf_switch(buf_switch), .halted(halted)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: compares each accepted fetch with the scoreboard
   always @(negedge clk) begin
      #1;
      if (fetch_ack && fetch_req) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL unexpected fetch actual=%h expected=none", fetch_addr);
         end else begin
            chk(tag_q.pop_front(), {3'd0, fetch_addr}, {3'd0, exp_q.pop_front()});
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1 chk(req, reg_rdata, exp);
   endtask

   task automatic fetch(input string req, input logic [28:0] exp);
      @(negedge clk);
      exp_q.push_back(exp); tag_q.push_back(req);
      fetch_ack = 1'b1;
      @(negedge clk);
      fetch_ack = 1'b0;
      #1;
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 active", {31'd0, active_set}, 0);
      chk("R1 req", {31'd0, fetch_req}, 0);
      chk("R1 halted", {31'd0, halted}, 0);
      chk("R1 switch", {31'd0, buf_switch}, 0);
      rd_chk("R1 curA", 3'd0, 0);
      rd_chk("R1 ctrl", 3'd4, 0);

      wr(3'd0, 32'hFFFF_FFFF);
      rd_chk("R2 curA mask", 3'd0, 32'h1FFF_FFF0);
      wr(3'd1, 32'hFFFF_FFFF);
      rd_chk("R3 endA mask", 3'd1, 32'hC000_0FF0);

      wr(3'd0, 32'h0000_5100);
      wr(3'd1, 32'h0000_0120);
      wr(3'd2, 32'h0000_9FE0);
      wr(3'd3, 32'h8000_0010);
      rd_chk("R2 curB", 3'd2, 32'h0000_9FE0);
      rd_chk("R3 endB", 3'd3, 32'h8000_0010);
      wr(3'd4, 32'h1);
      rd_chk("R10 ctrl", 3'd4, 1);
      chk("R10 req", {31'd0, fetch_req}, 1);
      repeat (3) @(negedge clk);
      #1 chk("R4 hold", {3'd0, fetch_addr}, 32'h5100);

      fetch("R4 A0", 29'h5100);
      fetch("R4 A1", 29'h5110);
      fetch("R6 A end", 29'h5120);
      chk("R6 switch", {31'd0, buf_switch}, 1);
      chk("R6 active", {31'd0, active_set}, 1);
      @(negedge clk); #1;
      chk("R6 pulse end", {31'd0, buf_switch}, 0);

      fetch("R6 B0", 29'h9FE0);
      fetch("R5 B1", 29'h9FF0);
      fetch("R5 wrap", 29'h9000);
      fetch("R7 B end", 29'h9010);
      chk("R7 halted", {31'd0, halted}, 1);
      chk("R7 req", {31'd0, fetch_req}, 0);
      chk("R7 active", {31'd0, active_set}, 1);
      rd_chk("R7 curB past end", 3'd2, 32'h0000_9020);
      rd_chk("R6 curA past end", 3'd0, 32'h0000_5130);

      wr(3'd4, 32'h1);
      #1 chk("R10 clear halt", {31'd0, halted}, 0);
      chk("R10 addr", {3'd0, fetch_addr}, 32'h9020);
      wr(3'd4, 32'h0);
      #1 chk("R10 disabled", {31'd0, fetch_req}, 0);
      rd_chk("R10 curB kept", 3'd2, 32'h0000_9020);
      wr(3'd4, 32'h1);

      wr(3'd2, 32'h0000_9050);
      fetch("R9 rewrite", 29'h9050);
      fetch("R9 next", 29'h9060);

      wr(3'd3, 32'h4000_0400);
      #1 chk("R8 jump addr", {3'd0, fetch_addr}, 32'h9400);
      fetch("R8 last B", 29'h9400);
      chk("R8 switch", {31'd0, buf_switch}, 1);
      chk("R8 active", {31'd0, active_set}, 0);
      rd_chk("R8 curB", 3'd2, 32'h0000_9410);
      fetch("R4 A resume", 29'h5130);
      wr(3'd1, 32'hC000_0200);
      fetch("R8 last stop A", 29'h5200);
      chk("R8 halted", {31'd0, halted}, 1);
      chk("R8 active kept", {31'd0, active_set}, 0);

      @(negedge clk); #1;
      chk("R4 queue empty", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule